// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a single-clock synchronous static RAM. It has no bus turnaround penalty and a 32-bit data path split into four byte lanes. On every enabled rising edge it captures an access. The address, the read/write select, the load/advance control and the active-low byte-write enables are registered together on that edge. Read data then flows out during the cycle that follows, taken from the registered address. Write data is late: it is sampled one enabled edge after its address. This lets reads and writes share the data bus back to back with no idle slots.

An internal two-bit burst counter can produce the next three addresses of a four-beat group, so only the first address of a burst needs to be supplied. A pin picks either a linear or an interleaved order. When the output-enable pin is high, the read path is cut asynchronously. The tri-state bus is modelled as a data port that is forced to zero plus a drive flag. A written word that is still waiting in the late-write stage is forwarded to a read of the same address, lane by lane. The storage depth is a parameter.

Top module: `lwfs_sram`

## Requirements
- R1: While `rst` is high, and on the cycle after a rising edge where it was high, `q_oe` is low and `q` is zero. Reset leaves no access and no pending write active.
- R2: A load edge (`cen_n`=0, `ld_n`=0, `sel_n`=0) with `rd`=1 starts a read. During the following cycle, with `oe_n` low, `q_oe` is 1 and `q` holds the stored word at the registered address.
- R3: A load edge with `rd`=0 starts a write, which registers the address and `ben_n`. The word is taken from `wdata` on the next enabled rising edge, and `q_oe` stays low during a write cycle.
- R4: `ben_n[i]`=0 writes lane i, which is `wdata[8i+7:8i]`. Lanes whose bit is 1 keep their old contents. Any mix from one to four lanes is allowed.
- R5: A read loaded on the same edge that takes the data of a write to the same address returns the new bytes in the enabled lanes and the stored bytes in the other lanes.
- R6: An enabled edge with `ld_n`=1 continues a burst. The next address comes from the counter, and the cycle keeps the type (read, write or deselect) of the last load.
- R7: With `mode_il`=0 the burst beats use low address bits base+0, +1, +2, +3 modulo 4. The upper bits stay fixed, and the fifth beat returns to the base address.
- R8: With `mode_il`=1 the beat low bits are base XOR 0, 1, 2, 3. The order wraps after four beats.
- R9: `oe_n`=1 makes `q_oe` low and `q` zero at once, with no clock edge needed, whatever the cycle type.
- R10: With `cen_n`=1 a rising edge is ignored. The current access, the burst counter and the pending late write all hold their state, and a stalled write takes its data on the next enabled edge.
- R11: A load edge with `sel_n`=1 is a deselect. It, and any burst continuing from it, reads and writes nothing, and `q_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| sel_n | input | 1 | Chip select sampled at load edges, active low |
| ld_n | input | 1 | 0: load a new address and cycle type; 1: advance the burst |
| rd | input | 1 | Cycle type at a load: 1 read, 0 write |
| ben_n | input | 4 | Byte-write enables, active low, bit i controls lane i |
| mode_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW (6) | Word address |
| wdata | input | 32 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | 32 | Flow-through read data, zero when not driven |
| q_oe | output | 1 | High when `q` drives the bus |

## Verification
The assertions assume that `mode_il` is held steady for the length of a burst. They also assume that `oe_n` only changes away from the clock edge, so any change of the drive flag during a stall can be traced back to the output enable. The bench changes every input on the falling edge and sets the burst order only between bursts. It also reads only addresses it has already written, so every expected word follows from the requirements and never depends on uninitialised storage.

// File: rtl/lwfs_pkg.sv
package lwfs_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of beat k in a four-beat group
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] k,
                                          input logic       il);
    logic [1:0] lin;
    lin = base + k;
    return il ? (base ^ k) : lin;
  endfunction
endpackage

// File: rtl/lwfs_burst.sv
module lwfs_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          mode_il,
  output logic [AW-1:0] addr_cur
);
  import lwfs_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= addr_in;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign addr_cur = {base_q[AW-1:2], beat_low(base_q[1:0], beat_q, mode_il)};
endmodule

// File: rtl/lwfs_ctrl.sv
module lwfs_ctrl #(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              sel_n,
  input  logic              rd,
  input  logic [LANES-1:0]  ben_n,
  output lwfs_pkg::op_e     op,
  output logic [LANES-1:0]  ben_n_q
);
  import lwfs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      op      <= OP_IDLE;
      ben_n_q <= '1;
    end else if (en) begin
      if (load) begin
        if (sel_n)   op <= OP_IDLE;
        else if (rd) op <= OP_READ;
        else         op <= OP_WRITE;
      end
      ben_n_q <= ben_n;
    end
  end
endmodule

// File: rtl/lwfs_store.sv
module lwfs_store #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          wr_take,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [LANES-1:0]              wr_ben_n,
  input  logic [LANES*lwfs_pkg::LANE_W-1:0] wdata,
  input  logic [AW-1:0]                 rd_addr,
  output logic [LANES*lwfs_pkg::LANE_W-1:0] rd_data
);
  import lwfs_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic             pend_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_ben_n;
  logic [DW-1:0]    pend_data;

  // late-write stage: data captured one enabled edge after its address
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else if (en) begin
      pend_v <= wr_take;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      pend_addr  <= wr_addr;
      pend_ben_n <= wr_ben_n;
      pend_data  <= wdata;
    end
  end

  logic hit;
  assign hit = pend_v && (pend_addr == rd_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] arr_b;

    always_ff @(posedge clk) begin
      if (en && pend_v && !pend_ben_n[i])
        mem[pend_addr] <= pend_data[i*LANE_W +: LANE_W];
    end

    assign arr_b = mem[rd_addr];
    assign rd_data[i*LANE_W +: LANE_W] =
      (hit && !pend_ben_n[i]) ? pend_data[i*LANE_W +: LANE_W] : arr_b;
  end
endmodule

// File: rtl/lwfs_sram.sv
module lwfs_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cen_n,
  input  logic                  sel_n,
  input  logic                  ld_n,
  input  logic                  rd,
  input  logic [LANES-1:0]      ben_n,
  input  logic                  mode_il,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*8-1:0]    wdata,
  input  logic                  oe_n,
  output logic [LANES*8-1:0]    q,
  output logic                  q_oe
);
  import lwfs_pkg::*;
  localparam int DW = LANES * LANE_W;

  logic             en, load;
  logic [AW-1:0]    addr_cur;
  op_e              op;
  logic [LANES-1:0] ben_n_q;
  logic [DW-1:0]    rd_data;

  assign en   = !cen_n;
  assign load = !ld_n;

  lwfs_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .addr_in(addr), .mode_il(mode_il), .addr_cur(addr_cur)
  );

  lwfs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .load(load), .sel_n(sel_n),
    .rd(rd), .ben_n(ben_n), .op(op), .ben_n_q(ben_n_q)
  );

  lwfs_store #(.AW(AW), .LANES(LANES)) u_store (
    .clk(clk), .rst(rst), .en(en), .wr_take(op == OP_WRITE),
    .wr_addr(addr_cur), .wr_ben_n(ben_n_q), .wdata(wdata),
    .rd_addr(addr_cur), .rd_data(rd_data)
  );

  assign q_oe = !oe_n && (op == OP_READ);
  assign q    = q_oe ? rd_data : '0;
endmodule

// File: rtl/lwfs_sram_chk.sv
module lwfs_sram_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cen_n,
  input logic               sel_n,
  input logic               ld_n,
  input logic               rd,
  input logic               oe_n,
  input logic [LANES*8-1:0] q,
  input logic               q_oe
);
  // R9: disabled output never drives and carries no data
  p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!q_oe && q == '0));

  // R9: undriven bus reads as zero
  p_q_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !q_oe |-> (q == '0));

  // R2: a loaded read drives the bus next cycle unless output is disabled
  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !ld_n && !sel_n && rd) |=> (oe_n || q_oe));

  // R3: a loaded write never drives the bus
  p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !ld_n && !sel_n && !rd) |=> !q_oe);

  // R11: deselect never drives the bus
  p_desel_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !ld_n && sel_n) |=> !q_oe);

  // R6: a read burst keeps reading on advance
  p_burst_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && ld_n && q_oe) |=> (q_oe || oe_n));

  // R10: a stalled edge leaves the drive state unless the output enable moved
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ((q_oe == $past(q_oe)) || (oe_n != $past(oe_n))));
endmodule

bind lwfs_sram lwfs_sram_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_lwfs_sram.sv
`timescale 1ns/1ps
module sim_lwfs_sram;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1, cen_n = 1'b0, sel_n = 1'b1, ld_n = 1'b0, rd = 1'b0;
  logic [LANES-1:0] ben_n = '1;
  logic mode_il = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] q;
  logic q_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lwfs_sram #(.AW(AW), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .cen_n(cen_n), .sel_n(sel_n), .ld_n(ld_n),
    .rd(rd), .ben_n(ben_n), .mode_il(mode_il), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .q(q), .q_oe(q_oe)
  );

  // reference model state
  logic [DW-1:0]    ref_mem [1<<AW];
  logic             m_valid = 1'b0, m_write = 1'b0;
  logic [AW-1:0]    m_base = '0;
  logic [1:0]       m_cnt = '0;
  logic [LANES-1:0] m_ben = '1;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = mode_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic c, input logic s,
                     input logic l, input logic rdx, input logic o,
                     input logic [3:0] b, input logic [AW-1:0] a,
                     input logic [DW-1:0] w, input string tag);
    logic exp_oe;
    logic [DW-1:0] exp_q;
    @(negedge clk);
    rst = r; cen_n = c; sel_n = s; ld_n = l; rd = rdx; oe_n = o;
    ben_n = b; addr = a; wdata = w;
    if (r) begin
      m_valid = 1'b0; m_write = 1'b0; m_cnt = '0; m_ben = '1;
    end else if (!c) begin
      if (m_valid && m_write)
        for (int k = 0; k < LANES; k++)
          if (!m_ben[k]) ref_mem[m_addr()][8*k +: 8] = w[8*k +: 8];
      if (!l) begin
        m_valid = !s; m_write = !rdx; m_base = a; m_cnt = '0;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      m_ben = b;
    end
    @(posedge clk);
    #5;
    exp_oe = m_valid && !m_write && !o;
    exp_q  = exp_oe ? ref_mem[m_addr()] : '0;
    chk(tag, "q_oe", {31'd0, q_oe}, {31'd0, exp_oe});
    chk(tag, "q", q, exp_q);
  endtask

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd9:    return "R9";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R6";
    endcase
  endfunction

  typedef struct packed {
    logic c, s, l, r, o;
    logic [3:0] b;
    logic [5:0] a;
    logic [31:0] w;
    logic [3:0] t;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,6'd5,32'h0,4'd3},         // R3 write 5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,6'd6,32'h11111111,4'd3},  // R3 write 6, data of 5
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd6,32'h22222222,4'd5},  // R5 forward
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd5,32'h0,4'd2},         // R2 read 5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'hA,6'd6,32'h0,4'd4},         // R4 lanes 0,2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd6,32'hAABBCCDD,4'd5},  // R5 partial forward
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd6,32'h0,4'd4},         // R4 committed
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,6'd6,32'h0,4'd11},        // R11 deselect
    '{1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,6'd6,32'hFFFFFFFF,4'd11}, // R11 burst of deselect
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd6,32'hFFFFFFFF,4'd11}, // R11 nothing written
    '{1'b0,1'b0,1'b0,1'b1,1'b1,4'hF,6'd6,32'h0,4'd9},         // R9 output off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'hF,6'd5,32'h0,4'd10},        // R10 stall holds read 6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,6'd8,32'h0,4'd10},        // R10 write 8
    '{1'b1,1'b0,1'b0,1'b1,1'b0,4'hF,6'd5,32'hDEAD0000,4'd10}, // R10 stall, data ignored
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd8,32'h12345678,4'd10}, // R10 data taken here
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'hF,6'd5,32'h0,4'd2}          // R2 read 5
  };

  initial begin
    #(64'd20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(1, 0, 0, 0, 1, 0, 4'hF, 6'd0, 32'h0, "R1");
    cyc(1, 0, 0, 0, 1, 0, 4'hF, 6'd0, 32'h0, "R1");

    for (int i = 0; i < NV; i++)
      cyc(0, TBL[i].c, TBL[i].s, TBL[i].l, TBL[i].r, TBL[i].o,
          TBL[i].b, TBL[i].a, TBL[i].w, tagname(TBL[i].t));

    // R6: linear write burst filling 16..19, last data on a deselect load
    mode_il = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 4'h0, 6'd16, 32'h0, "R6");
    for (int k = 0; k < 3; k++)
      cyc(0, 0, 0, 1, 0, 0, 4'h0, 6'd0, 32'hA0000000 + k, "R6");
    cyc(0, 0, 1, 0, 0, 0, 4'h0, 6'd0, 32'hA0000003, "R6");

    // R7 / R8: read bursts from every base offset, five beats to see the wrap
    for (int m = 0; m < 2; m++) begin
      mode_il = m[0];
      for (int bo = 0; bo < 4; bo++) begin
        cyc(0, 0, 0, 0, 1, 0, 4'hF, 6'(16 + bo), 32'h0, m ? "R8" : "R7");
        for (int k = 0; k < 4; k++)
          cyc(0, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, m ? "R8" : "R7");
      end
    end

    // R10: stall in the middle of a linear burst
    mode_il = 1'b0;
    cyc(0, 0, 0, 0, 1, 0, 4'hF, 6'd17, 32'h0, "R10");
    cyc(0, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R10");
    cyc(0, 1, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R10");
    cyc(0, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R10");
    cyc(0, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R10");

    // R9: asynchronous output enable within a read cycle
    cyc(0, 0, 0, 0, 1, 0, 4'hF, 6'd18, 32'h0, "R9");
    #2 oe_n = 1'b1;
    #1 chk("R9", "q_oe async off", {31'd0, q_oe}, 32'd0);
    chk("R9", "q async off", q, 32'h0);
    oe_n = 1'b0;
    #1 chk("R9", "q async on", q, 32'hA0000002);

    // R1: reset in the middle of a read
    cyc(0, 0, 0, 0, 1, 0, 4'hF, 6'd19, 32'h0, "R2");
    cyc(1, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R1");
    cyc(0, 0, 0, 1, 1, 0, 4'hF, 6'd0, 32'h0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule